// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings an external DDR3 device from power-up to a usable state under software control. Software programs a clock-enable wait and the four mode-register values through a small register port. It drops the device reset through a control bit. It then sets a start bit. The sequencer keeps CKE low for the programmed number of wait units, raises CKE, sends the mode-register-set commands and a long ZQ calibration command on a registered command output, and clears the start bit itself when done. Software polls that bit to learn when the sequence has completed.

One wait unit is N DRAM clocks, with N equal to 2 or 3, chosen by a static configuration input. Only the low 17 bits of the wait register form the count. The register keeps all 32 bits for readback. Every command cycle that carries no mode-register-set or calibration command presents a NOP.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After reset, `dram_cke` is 0, `dram_reset_n` is 0, `cmd_valid` is 0, `cmd_code` is NOP (3'b111), the control register (address 0) reads 0x00000002 and the wait register (address 1) reads 0x00c80064.
- R2: Control bit 1 is the software reset bit, and `dram_reset_n` is always its inverse. Writing address 0 updates it at any time.
- R3: A write to address 0 with bit 0 set starts the sequence. Writing the wait register alone starts nothing. With wait count D (wait register bits 16:0, upper bits ignored) and N = 3 when `cfg_div3` is 1 and N = 2 otherwise, CKE stays low for the D*N clocks after the start edge and is high from the next edge on.
- R4: A wait count of zero raises CKE on the first edge after the start edge.
- R5: On the edge after CKE rises, the sequencer issues MRS (code 3'b000) for MR2, then MR3, MR1 and MR0, each 4 clocks after the one before. The bank output equals the mode-register number. The address equals its programmed value: MR0 is bits 15:0 and MR1 is bits 31:16 of address 2; MR2 is bits 15:0 and MR3 is bits 31:16 of address 3.
- R6: A ZQCL command (code 3'b110, bank 0, address 0x0400) is issued 12 clocks after MR0.
- R7: `cmd_valid` is high only in the cycles of those five commands. In every other cycle `cmd_code` is NOP.
- R8: Control bit 0 reads 1 from the start edge until 512 clocks after the ZQCL command, then reads 0.
- R9: Setting control bit 0 while a sequence runs has no effect on the command timing or on completion.
- R10: Once raised, CKE stays high until the block reset, including after completion.
- R11: All four register addresses read back what was last written. The exception is control bit 0, which reflects the running state.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div3 | input | 1 | Wait-unit length select: 1 gives 3 clocks, 0 gives 2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| dram_cke | output | 1 | DRAM clock enable |
| dram_reset_n | output | 1 | DRAM reset, active low |
| cmd_valid | output | 1 | High in a cycle carrying MRS or ZQCL |
| cmd_code | output | 3 | {RAS#, CAS#, WE#} command encoding |
| cmd_bank | output | 3 | Bank address of the command |
| cmd_addr | output | 16 | Address bus of the command |

## Verification
The assertions assume that `cfg_div3` does not change while a sequence runs. They also assume that software releases the device reset before it sets the start bit, because a command issued with reset asserted is flagged. The stimulus sets `cfg_div3` only while the block is idle or in reset. Every sequence starts after the reset bit has been written to 0. A scoreboard predicts the cycle and the contents of each of the five commands from the programmed wait and divider.

// File: rtl/ddr3_seq_pkg.sv
// Package: shared encodings and state type for the DDR3 power-up sequencer.
// Assumes the command bus follows the DDR3 {RAS#, CAS#, WE#} encoding.
package ddr3_seq_pkg;
    localparam int MR_W  = 16;   // mode-register / address bus width
    localparam int BA_W  = 3;    // bank address width
    localparam int REG_W = 32;   // register port data width

    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_MRS  = 3'b000;
    localparam logic [2:0] CMD_ZQCL = 3'b110;
    localparam logic [MR_W-1:0] ZQCL_ADDR = 16'h0400;   // A10 selects the long form

    typedef enum logic [1:0] {
        ST_IDLE,    // waiting for a start request
        ST_WAIT,    // CKE held low, counting wait units
        ST_CMDS,    // issuing MRS commands and ZQCL
        ST_ZQW      // waiting out the calibration time
    } seq_state_t;
endpackage

// File: rtl/ddr3_seq_regs.sv
// Register file for the sequencer.
// Address 0: control (bit 0 start/busy, bit 1 device reset).
// Address 1: wait count. Address 2: {MR1, MR0}. Address 3: {MR3, MR2}.
// Assumes the read data is sampled combinationally from reg_addr.
module ddr3_seq_regs
    import ddr3_seq_pkg::*;
#(
    parameter int              DLY_W   = 17,
    parameter logic [REG_W-1:0] DLY_RST = 32'h00c80064,
    parameter logic [REG_W-1:0] MRA_RST = 32'h0000_0000,
    parameter logic [REG_W-1:0] MRB_RST = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    output logic             start,
    output logic             rst_bit,
    output logic [DLY_W-1:0] dly_cnt,
    output logic [MR_W-1:0]  mr_val [4]
);
    localparam int NREG = 4;

    logic [REG_W-1:0] store_q [NREG];
    logic             rst_q;

    // Control register write: reset bit is writeable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rst_q <= 1'b1;
        else if (reg_wr && reg_addr == 2'd0) rst_q <= reg_wdata[1];
    end

    // Data registers 1..3 hold the wait count and the mode-register values.
    genvar gi;
    generate
        for (gi = 1; gi < NREG; gi++) begin : g_store
            localparam logic [REG_W-1:0] RST_V =
                (gi == 1) ? DLY_RST : (gi == 2) ? MRA_RST : MRB_RST;
            always_ff @(posedge clk) begin
                if (!rst_n)                               store_q[gi] <= RST_V;
                else if (reg_wr && reg_addr == 2'(gi))    store_q[gi] <= reg_wdata;
            end
        end
    endgenerate

    assign store_q[0] = {{(REG_W-2){1'b0}}, rst_q, busy};

    // Start request: a set of bit 0 while idle; ignored while busy.
    assign start   = reg_wr && (reg_addr == 2'd0) && reg_wdata[0] && !busy;
    assign rst_bit = rst_q;
    assign dly_cnt = store_q[1][DLY_W-1:0];

    // Split the packed mode-register words into four values.
    assign mr_val[0] = store_q[2][MR_W-1:0];
    assign mr_val[1] = store_q[2][REG_W-1:MR_W];
    assign mr_val[2] = store_q[3][MR_W-1:0];
    assign mr_val[3] = store_q[3][REG_W-1:MR_W];

    // Read multiplexer.
    always_comb reg_rdata = store_q[reg_addr];
endmodule

// File: rtl/ddr3_seq_prescale.sv
// Wait-unit prescaler: emits one tick every N clocks while run is high.
// N is 3 when div3 is set, otherwise 2. Assumes div3 is static during a run.
module ddr3_seq_prescale #(
    parameter int PC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div3,
    output logic tick
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    assign lim  = div3 ? PC_W'(2) : PC_W'(1);
    assign tick = run && (pc_q == lim);

    // Phase counter: restarts whenever the wait is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pc_q <= '0;
        else if (tick)      pc_q <= '0;
        else                pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/ddr3_seq_ctrl.sv
// Sequencing engine: CKE wait, MRS in order MR2, MR3, MR1, MR0, then ZQCL,
// then the calibration wait. Command outputs are registered; NOP otherwise.
// Assumes TMRD, TMOD and TZQ are at least 1.
module ddr3_seq_ctrl
    import ddr3_seq_pkg::*;
#(
    parameter int DLY_W = 17,
    parameter int TMRD  = 4,
    parameter int TMOD  = 12,
    parameter int TZQ   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] dly_cnt,
    input  logic             tick,
    input  logic [MR_W-1:0]  mr_val [4],
    output logic             busy,
    output logic             wait_run,
    output logic             cke,
    output logic             cmd_valid,
    output logic [2:0]       cmd_code,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [MR_W-1:0]  cmd_addr
);
    localparam int TMAX = (TZQ > TMOD) ? ((TZQ > TMRD) ? TZQ : TMRD)
                                       : ((TMOD > TMRD) ? TMOD : TMRD);
    localparam int WC_W = $clog2(TMAX + 1);
    localparam logic [2:0] LAST_MRS = 3'd3;
    localparam logic [2:0] ZQ_IDX   = 3'd4;

    seq_state_t       state_q;
    logic [DLY_W-1:0] dcnt_q;
    logic [WC_W-1:0]  wcnt_q;
    logic [2:0]       idx_q;
    logic             cke_q;
    logic             vld_q;
    logic [2:0]       code_q;
    logic [BA_W-1:0]  bank_q;
    logic [MR_W-1:0]  addr_q;
    logic [2:0]       sel_code;
    logic [BA_W-1:0]  sel_bank;
    logic [MR_W-1:0]  sel_addr;

    // Command selection by slot index: MR2, MR3, MR1, MR0, ZQCL.
    always_comb begin
        sel_code = CMD_MRS;
        unique case (idx_q)
            3'd0:    begin sel_bank = BA_W'(2); sel_addr = mr_val[2]; end
            3'd1:    begin sel_bank = BA_W'(3); sel_addr = mr_val[3]; end
            3'd2:    begin sel_bank = BA_W'(1); sel_addr = mr_val[1]; end
            3'd3:    begin sel_bank = BA_W'(0); sel_addr = mr_val[0]; end
            default: begin sel_bank = '0; sel_addr = ZQCL_ADDR; sel_code = CMD_ZQCL; end
        endcase
    end

    // Main sequencer: state, counters, CKE and the registered command bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            wcnt_q  <= '0;
            idx_q   <= '0;
            cke_q   <= 1'b0;
            vld_q   <= 1'b0;
            code_q  <= CMD_NOP;
            bank_q  <= '0;
            addr_q  <= '0;
        end else begin
            vld_q  <= 1'b0;
            code_q <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WAIT;
                        dcnt_q  <= dly_cnt;
                    end
                end
                ST_WAIT: begin
                    if (dcnt_q == '0) begin
                        cke_q   <= 1'b1;
                        state_q <= ST_CMDS;
                        idx_q   <= '0;
                        wcnt_q  <= '0;
                    end else if (tick) begin
                        dcnt_q <= dcnt_q - 1'b1;
                    end
                end
                ST_CMDS: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end else begin
                        vld_q  <= 1'b1;
                        code_q <= sel_code;
                        bank_q <= sel_bank;
                        addr_q <= sel_addr;
                        if (idx_q == ZQ_IDX) begin
                            wcnt_q  <= WC_W'(TZQ - 1);
                            state_q <= ST_ZQW;
                        end else begin
                            wcnt_q <= (idx_q == LAST_MRS) ? WC_W'(TMOD - 1) : WC_W'(TMRD - 1);
                            idx_q  <= idx_q + 1'b1;
                        end
                    end
                end
                ST_ZQW: begin
                    if (wcnt_q != '0) wcnt_q  <= wcnt_q - 1'b1;
                    else              state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign wait_run  = (state_q == ST_WAIT);
    assign cke       = cke_q;
    assign cmd_valid = vld_q;
    assign cmd_code  = code_q;
    assign cmd_bank  = bank_q;
    assign cmd_addr  = addr_q;
endmodule

// File: rtl/ddr3_pwrup_seq.sv
// Top of the DDR3 power-up sequencer: register file, wait prescaler and
// sequencing engine. Assumes cfg_div3 is held stable while a sequence runs.
module ddr3_pwrup_seq
    import ddr3_seq_pkg::*;
#(
    parameter int DLY_W = 17,
    parameter int TMRD  = 4,
    parameter int TMOD  = 12,
    parameter int TZQ   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_div3,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             dram_cke,
    output logic             dram_reset_n,
    output logic             cmd_valid,
    output logic [2:0]       cmd_code,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [MR_W-1:0]  cmd_addr
);
    logic             busy;
    logic             start;
    logic             rst_bit;
    logic             wait_run;
    logic             tick;
    logic [DLY_W-1:0] dly_cnt;
    logic [MR_W-1:0]  mr_val [4];

    ddr3_seq_regs #(.DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .start(start), .rst_bit(rst_bit), .dly_cnt(dly_cnt), .mr_val(mr_val)
    );

    ddr3_seq_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .div3(cfg_div3), .tick(tick)
    );

    ddr3_seq_ctrl #(.DLY_W(DLY_W), .TMRD(TMRD), .TMOD(TMOD), .TZQ(TZQ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dly_cnt(dly_cnt), .tick(tick),
        .mr_val(mr_val), .busy(busy), .wait_run(wait_run), .cke(dram_cke),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr)
    );

    assign dram_reset_n = ~rst_bit;
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
// Checker for the DDR3 power-up sequencer, bound to the top module.
// Assumes cfg_div3 is stable during a run and the reset bit is released
// before a start request.
module ddr3_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       reset_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       busy
);
    // CKE never falls outside reset.
    assert_cke_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // Idle command cycles carry NOP.
    assert_idle_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> cmd_code == 3'b111);

    // A valid command is either MRS or ZQCL.
    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code == 3'b000 || cmd_code == 3'b110));

    // Commands only follow the CKE rise.
    assert_cmd_after_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cke);

    // Commands are never back to back.
    assert_cmd_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // Commands only appear while the sequence is reported busy.
    assert_cmd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // CKE rises only inside a running sequence.
    assert_cke_rise_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> busy);

    // No command reaches a device held in reset.
    assert_no_cmd_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_n |-> !cmd_valid);
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke(dram_cke), .reset_n(dram_reset_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .busy(busy)
);

// File: tb/ddr3_pwrup_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the sequence driver pushes the predicted commands with
// their cycle numbers; a monitor pops and compares them as they appear.
module ddr3_pwrup_seq_test;
    localparam int TMRD = 4;
    localparam int TMOD = 12;
    localparam int TZQ  = 512;

    typedef struct {
        int          cyc;
        logic [2:0]  code;
        logic [2:0]  bank;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_div3 = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dram_cke, dram_reset_n, cmd_valid;
    logic [2:0]  cmd_code, cmd_bank;
    logic [15:0] cmd_addr;

    int   edge_cnt = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb [$];

    ddr3_pwrup_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_div3(cfg_div3), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dram_cke(dram_cke), .dram_reset_n(dram_reset_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    always #2 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each command with the scoreboard head; NOP elsewhere.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected command", {29'd0, cmd_code}, 32'h7);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(edge_cnt == e.cyc, {e.tag, " cycle"}, edge_cnt, e.cyc);
                    check(cmd_code == e.code, {e.tag, " code"}, cmd_code, e.code);
                    check(cmd_bank == e.bank, {e.tag, " bank"}, cmd_bank, e.bank);
                    check(cmd_addr == e.addr, {e.tag, " addr"}, cmd_addr, e.addr);
                end
            end else if (cmd_code != 3'b111) begin
                check(1'b0, "R7 idle code", cmd_code, 32'h7);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_edge(input int t);
        while (edge_cnt < t) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one full sequence with wait count d and predicts every command.
    task automatic run_seq(input logic [31:0] dreg, input logic [15:0] m0, m1, m2, m3,
                           input bit poke);
        int d, n, e0, k, zq;
        d = int'(dreg[16:0]);
        n = cfg_div3 ? 3 : 2;
        wr(2'd1, dreg);
        wr(2'd2, {m1, m0});
        wr(2'd3, {m3, m2});
        @(negedge clk);
        e0 = edge_cnt + 1;
        k  = e0 + 1 + d * n;
        zq = k + 1 + 3 * TMRD + TMOD;
        sb.push_back('{k + 1,            3'b000, 3'd2, m2, "R5 MR2"});
        sb.push_back('{k + 1 + TMRD,     3'b000, 3'd3, m3, "R5 MR3"});
        sb.push_back('{k + 1 + 2 * TMRD, 3'b000, 3'd1, m1, "R5 MR1"});
        sb.push_back('{k + 1 + 3 * TMRD, 3'b000, 3'd0, m0, "R5 MR0"});
        sb.push_back('{zq,               3'b110, 3'd0, 16'h0400, "R6 ZQCL"});
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd_check(2'd0, 32'h1, "R8 busy after start");
        if (poke) wr(2'd0, 32'h1);   // R9: second start while running
        if (d > 0) begin
            wait_edge(k - 1);
            check(dram_cke == 1'b0, "R3 cke low at end of wait", dram_cke, 0);
        end
        wait_edge(k);
        check(dram_cke == 1'b1, d == 0 ? "R4 cke high after zero wait" : "R3 cke rises",
              dram_cke, 1);
        wait_edge(zq + TZQ - 1);
        rd_check(2'd0, 32'h1, "R8 busy until calibration wait ends");
        wait_edge(zq + TZQ);
        rd_check(2'd0, 32'h0, "R8 init bit cleared");
        check(sb.size() == 0, "R6 all commands seen", sb.size(), 0);
        repeat (20) @(negedge clk);
        check(dram_cke == 1'b1, "R10 cke held high after completion", dram_cke, 1);
    endtask

    initial begin
        fork
            begin
                #(4 * 200000);
                check(1'b0, "watchdog expired", 0, 1);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dram_cke == 1'b0, "R1 cke after reset", dram_cke, 0);
        check(dram_reset_n == 1'b0, "R1 reset_n after reset", dram_reset_n, 0);
        check(cmd_valid == 1'b0 && cmd_code == 3'b111, "R1 command after reset",
              {cmd_valid, cmd_code}, 32'h7);
        rd_check(2'd0, 32'h2, "R1 control reset value");
        rd_check(2'd1, 32'h00c80064, "R1 wait register reset value");
        // R2: software reset bit drives reset_n
        wr(2'd0, 32'h0);
        check(dram_reset_n == 1'b1, "R2 reset released", dram_reset_n, 1);
        wr(2'd0, 32'h2);
        check(dram_reset_n == 1'b0, "R2 reset reasserted", dram_reset_n, 0);
        wr(2'd0, 32'h0);
        // R3/R11: writing the wait register does not start anything
        wr(2'd1, 32'h5);
        rd_check(2'd1, 32'h5, "R11 wait register readback");
        repeat (10) @(negedge clk);
        check(dram_cke == 1'b0, "R3 no start on wait write", dram_cke, 0);
        rd_check(2'd0, 32'h0, "R3 idle after wait write");
        wr(2'd2, 32'h0006_1d70);
        rd_check(2'd2, 32'h0006_1d70, "R11 MR0/MR1 readback");
        // Run 1: N = 2, D = 5, with a second start request during the wait (R9)
        run_seq(32'h5, 16'h1d70, 16'h0006, 16'h0018, 16'h0000, 1'b1);
        // Run 2: N = 3, zero wait (R4)
        do_reset();
        cfg_div3 = 1'b1;
        wr(2'd0, 32'h0);
        run_seq(32'h0, 16'h0520, 16'h0044, 16'h0008, 16'h0004, 1'b0);
        // Run 3: N = 3, upper bits of the wait register ignored (R3), D = 3
        do_reset();
        wr(2'd0, 32'h0);
        run_seq(32'hfffe_0003, 16'h0a31, 16'h0001, 16'h0010, 16'h0002, 1'b1);
        rd_check(2'd1, 32'hfffe_0003, "R11 wait register full readback");
        // Run 4: N = 2, D = 9
        do_reset();
        cfg_div3 = 1'b0;
        wr(2'd0, 32'h0);
        run_seq(32'h9, 16'h0210, 16'h0002, 16'h0000, 16'h0000, 1'b0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule